// File: doc/BRIEF.md
# Multi-Block Erase Scheduler with Suspend

This block orders a block erase that spans any subset of a memory array of uniform blocks. Once the erase command has been recognised upstream, every block number presented on the select strobe is added to a pending list held as a bitmap. A window of microsecond ticks follows each selection, and each new selection restarts it. When the window runs out, the scheduler hands blocks one at a time to the erase engine, lowest number first. It uses a request/done handshake for this and passes over any block whose protect flag is set.

Suspend has two behaviours. If it arrives while blocks are still being gathered, it takes hold at once. If it arrives during erasing, it takes hold only when the block being erased finishes. Resume takes effect only while the host reports that it is in array-read mode. A read/reset that arrives during the window cancels the whole operation after a short abort delay. The same read/reset is ignored while the erase is suspended or running. When every selected block is protected, the scheduler stays busy for a fixed drain time and then ends without issuing any request.

Top module: `ers_sched`

## Requirements
- R1: After reset, busy_o, suspended_o and erase_req_o are all low.
- R2: Each selected unprotected block is erased exactly once, and blocks are handed out in ascending block number regardless of selection order.
- R3: erase_req_o for the first block rises on the second clock after the edge that completes WIN_TICKS ticks counted from the last accepted selection. Each accepted selection restarts this count, and busy_o is high from the first selection on.
- R4: A selection strobe has no effect once the window has closed. This covers erasing, suspension and the time after a resume.
- R5: A block whose prot_i bit is set is never requested, and no error or status is raised for it.
- R6: If every selected block is protected, no request is issued. busy_o stays high for WIN_TICKS + DRAIN_TICKS + 1 clocks after the selection edge and then falls.
- R7: A suspend during the selection window sets suspended_o and clears busy_o on the next clock, and no request is issued while suspended.
- R8: A resume accepted in suspension clears suspended_o on the next clock and raises erase_req_o on the clock after that.
- R9: Resume is ignored unless rd_array_i is high in the same cycle.
- R10: A suspend during erasing leaves erase_req_o asserted until erase_done_i. The scheduler then suspends, with cur_blk_o naming the next block to be erased.
- R11: Suspend and resume can be repeated any number of times within one operation, and no block is lost or repeated.
- R12: abort_i during the selection window discards the list, keeps busy_o high for ABORT_TICKS clocks and returns to idle without any request.
- R13: abort_i is ignored while suspended or erasing.
- R14: erase_req_o and erase_blk_o stay stable until erase_done_i. The request drops on the clock that follows the done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| us_tick_i | input | 1 | One-cycle pulse each microsecond |
| sel_valid_i | input | 1 | Block selection strobe |
| sel_blk_i | input | BLK_W | Selected block number |
| suspend_i | input | 1 | Suspend request |
| resume_i | input | 1 | Resume request |
| rd_array_i | input | 1 | Host is in array-read mode |
| abort_i | input | 1 | Read/reset command |
| prot_i | input | NUM_BLOCKS | Per-block protect flags |
| erase_done_i | input | 1 | Erase engine finished current block |
| erase_req_o | output | 1 | Erase request to the engine |
| erase_blk_o | output | BLK_W | Block to erase |
| busy_o | output | 1 | Operation in progress, not suspended |
| suspended_o | output | 1 | Erase suspended |
| cur_blk_o | output | BLK_W | Block being erased or next to be erased |

## Verification
The assertions assume three things about the inputs. The protect flags hold still from the start of an operation until it ends. erase_done_i is only pulsed while a request is outstanding. A limit of at least one tick is always configured. The stimulus changes prot_i only while the scheduler is idle. Its erase engine model raises done only after it has seen the request for a fixed number of cycles, and it lowers done on the next cycle. Each control input is held for a single clock, so the scheduler sees every strobe exactly once.

// File: rtl/ers_pkg.sv
package ers_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_COLLECT, ST_PICK, ST_ERASE, ST_SUSP, ST_DRAIN, ST_ABORT
  } ers_state_e;
endpackage

// File: rtl/ers_tick_timer.sv
module ers_tick_timer #(
  parameter int CNT_W = 7
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             tick_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic             expire_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end   = (cnt_q == CNT_W'(limit_i - 1'b1));
  assign expire_o = tick_i && at_end;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (clear_i)  cnt_q <= '0;
    else if (tick_i)   cnt_q <= at_end ? '0 : cnt_q + 1'b1;
  end

  AST_CNT_BELOW_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < limit_i) else $error("tick count past limit"); // R3
endmodule

// File: rtl/ers_lowest_set.sv
module ers_lowest_set #(
  parameter int N = 128,
  parameter int W = 7
) (
  input  logic [N-1:0] vec_i,
  output logic         found_o,
  output logic [W-1:0] idx_o
);
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (vec_i[i]) begin
        found_o = 1'b1;
        idx_o   = W'(i);
      end
    end
  end

  always_comb begin
    if (found_o) begin
      AST_HIT_IS_SET: assert (vec_i[idx_o]) else $error("picked clear bit"); // R2
      AST_HIT_IS_LOWEST: assert ((vec_i & ((N'(1) << idx_o) - N'(1))) == '0)
        else $error("lower bit skipped"); // R2
    end
  end
endmodule

// File: rtl/ers_blk_list.sv
module ers_blk_list #(
  parameter int N = 128,
  parameter int W = 7
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         flush_i,
  input  logic         set_i,
  input  logic [W-1:0] set_idx_i,
  input  logic         clr_i,
  input  logic [W-1:0] clr_idx_i,
  output logic [N-1:0] map_o
);
  for (genvar g = 0; g < N; g++) begin : g_bit
    logic bit_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                bit_q <= 1'b0;
      else if (flush_i)                           bit_q <= 1'b0;
      else if (set_i && (set_idx_i == W'(g)))     bit_q <= 1'b1;
      else if (clr_i && (clr_idx_i == W'(g)))     bit_q <= 1'b0;
    end
    assign map_o[g] = bit_q;
  end
endmodule

// File: rtl/ers_sched.sv
module ers_sched
  import ers_pkg::*;
#(
  parameter int NUM_BLOCKS  = 128,
  parameter int WIN_TICKS   = 50,
  parameter int ABORT_TICKS = 10,
  parameter int DRAIN_TICKS = 80,
  localparam int BLK_W      = $clog2(NUM_BLOCKS)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  us_tick_i,
  input  logic                  sel_valid_i,
  input  logic [BLK_W-1:0]      sel_blk_i,
  input  logic                  suspend_i,
  input  logic                  resume_i,
  input  logic                  rd_array_i,
  input  logic                  abort_i,
  input  logic [NUM_BLOCKS-1:0] prot_i,
  input  logic                  erase_done_i,
  output logic                  erase_req_o,
  output logic [BLK_W-1:0]      erase_blk_o,
  output logic                  busy_o,
  output logic                  suspended_o,
  output logic [BLK_W-1:0]      cur_blk_o
);
  localparam int MAX_A = (WIN_TICKS > ABORT_TICKS) ? WIN_TICKS : ABORT_TICKS;
  localparam int MAX_T = (MAX_A > DRAIN_TICKS) ? MAX_A : DRAIN_TICKS;
  localparam int CNT_W = $clog2(MAX_T + 1);

  ers_state_e            state_q, state_d;
  logic [BLK_W-1:0]      cur_q, cur_d;
  logic                  pend_q, pend_d;
  logic                  any_q, any_d;
  logic [NUM_BLOCKS-1:0] map, cand;
  logic                  found, expire, tmr_clear, sel_accept, list_flush, list_clr;
  logic [BLK_W-1:0]      low_idx;
  logic [CNT_W-1:0]      limit;

  assign cand = map & ~prot_i;

  assign sel_accept = sel_valid_i &&
                      ((state_q == ST_IDLE) ||
                       ((state_q == ST_COLLECT) && !abort_i && !suspend_i));
  assign list_flush = ((state_q == ST_COLLECT) && abort_i) ||
                      ((state_q == ST_PICK) && !found);
  assign list_clr   = (state_q == ST_ERASE) && erase_done_i;
  assign tmr_clear  = sel_accept || (state_d != state_q);

  always_comb begin
    case (state_q)
      ST_DRAIN: limit = CNT_W'(DRAIN_TICKS);
      ST_ABORT: limit = CNT_W'(ABORT_TICKS);
      default:  limit = CNT_W'(WIN_TICKS);
    endcase
  end

  ers_blk_list #(.N(NUM_BLOCKS), .W(BLK_W)) u_list (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .flush_i   (list_flush),
    .set_i     (sel_accept),
    .set_idx_i (sel_blk_i),
    .clr_i     (list_clr),
    .clr_idx_i (cur_q),
    .map_o     (map)
  );

  ers_lowest_set #(.N(NUM_BLOCKS), .W(BLK_W)) u_pick (
    .vec_i   (cand),
    .found_o (found),
    .idx_o   (low_idx)
  );

  ers_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (tmr_clear),
    .tick_i   (us_tick_i),
    .limit_i  (limit),
    .expire_o (expire)
  );

  always_comb begin
    state_d = state_q;
    cur_d   = cur_q;
    pend_d  = pend_q;
    any_d   = any_q;
    unique case (state_q)
      ST_IDLE: if (sel_valid_i) begin
        state_d = ST_COLLECT;
        pend_d  = 1'b0;
        any_d   = 1'b0;
      end
      ST_COLLECT: begin
        if (abort_i)                        state_d = ST_ABORT;
        else if (suspend_i) begin
          state_d = ST_SUSP;            // immediate: nothing started yet
          cur_d   = low_idx;
        end
        else if (!sel_valid_i && expire)    state_d = ST_PICK;
      end
      ST_PICK: begin
        if (found) begin
          cur_d   = low_idx;
          state_d = (pend_q || suspend_i) ? ST_SUSP : ST_ERASE;
        end else begin
          state_d = any_q ? ST_IDLE : ST_DRAIN;
        end
        pend_d = 1'b0;
      end
      ST_ERASE: begin
        if (suspend_i) pend_d = 1'b1;   // honoured at next step boundary
        if (erase_done_i) begin
          any_d   = 1'b1;
          state_d = ST_PICK;
        end
      end
      ST_SUSP:  if (resume_i && rd_array_i) state_d = ST_PICK;
      ST_DRAIN: if (expire) state_d = ST_IDLE;
      ST_ABORT: if (expire) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cur_q   <= '0;
      pend_q  <= 1'b0;
      any_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cur_q   <= cur_d;
      pend_q  <= pend_d;
      any_q   <= any_d;
    end
  end

  assign erase_req_o = (state_q == ST_ERASE);
  assign erase_blk_o = cur_q;
  assign cur_blk_o   = cur_q;
  assign suspended_o = (state_q == ST_SUSP);
  assign busy_o      = (state_q != ST_IDLE) && (state_q != ST_SUSP);

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o && !erase_done_i |=> erase_req_o && $stable(erase_blk_o))
    else $error("request dropped early"); // R14
  AST_REQ_RELEASE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o && erase_done_i |=> !erase_req_o)
    else $error("request held after done"); // R14
  AST_SUSP_WAITS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    erase_req_o && !erase_done_i |=> !suspended_o)
    else $error("suspend cut an erase step"); // R10
  AST_SUSP_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    suspended_o && !(resume_i && rd_array_i) |=> suspended_o)
    else $error("left suspend without valid resume"); // R9
  AST_NO_PROT_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(erase_req_o) |-> !prot_i[erase_blk_o])
    else $error("protected block requested"); // R5
endmodule

// File: tb/tb_ers_sched.sv
module tb_ers_sched;
  localparam int NB  = 16;
  localparam int BW  = 4;
  localparam int WIN = 4;
  localparam int ABT = 2;
  localparam int DRN = 3;
  localparam int LAT = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b1;
  logic sel_v = 1'b0;
  logic [BW-1:0] sel_b = '0;
  logic susp = 1'b0, resm = 1'b0, rd_arr = 1'b1, abrt = 1'b0;
  logic [NB-1:0] prot = '0;
  logic done = 1'b0;
  logic req, busy, suspd;
  logic [BW-1:0] eblk, cblk;

  int n_chk = 0, n_err = 0;
  int log_q [0:31];
  int n_log = 0;
  int rsp_cnt = 0;

  always #2.5 clk = ~clk;

  ers_sched #(.NUM_BLOCKS(NB), .WIN_TICKS(WIN), .ABORT_TICKS(ABT), .DRAIN_TICKS(DRN)) dut (
    .clk_i(clk), .rst_ni(rst_n), .us_tick_i(tick), .sel_valid_i(sel_v), .sel_blk_i(sel_b),
    .suspend_i(susp), .resume_i(resm), .rd_array_i(rd_arr), .abort_i(abrt), .prot_i(prot),
    .erase_done_i(done), .erase_req_o(req), .erase_blk_o(eblk), .busy_o(busy),
    .suspended_o(suspd), .cur_blk_o(cblk)
  );

  // erase engine model
  initial begin
    forever begin
      @(negedge clk);
      if (done) begin
        done = 1'b0;
        rsp_cnt = 0;
      end else if (req) begin
        rsp_cnt++;
        if (rsp_cnt == LAT) begin
          done = 1'b1;
          if (n_log < 32) log_q[n_log] = int'(eblk);
          n_log++;
        end
      end
    end
  end

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired act=hung exp=done");
    summary();
  end

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic pick(input int b);
    sel_v = 1'b1; sel_b = BW'(b);
    @(negedge clk);
    sel_v = 1'b0;
  endtask

  task automatic pulse_susp();
    susp = 1'b1; @(negedge clk); susp = 1'b0;
  endtask

  task automatic pulse_resume();
    resm = 1'b1; @(negedge clk); resm = 1'b0;
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 400 && (busy || suspd); k++) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic wait_req(output int k);
    k = 1;
    while (!req && k < 200) begin @(negedge clk); k++; end
  endtask

  task automatic wait_susp();
    for (int k = 0; k < 200 && !suspd; k++) @(negedge clk);
  endtask

  initial begin
    int k, lo, hi, b2, cnt, saw;
    repeat (3) @(negedge clk);
    // R1
    check("R1 busy", int'(busy), 0);
    check("R1 suspended", int'(suspd), 0);
    check("R1 req", int'(req), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 busy after release", int'(busy), 0);

    // R2 R3: out-of-order selection, retriggered window
    n_log = 0;
    pick(9);
    check("R3 busy during window", int'(busy), 1);
    repeat (WIN - 2) @(negedge clk);
    pick(2);
    repeat (WIN - 2) @(negedge clk);
    check("R3 no request before window closes", int'(req), 0);
    pick(5);
    wait_req(k);
    check("R3 request delay after last select", k, WIN + 2);
    // R4: selection while erasing is ignored
    pick(12);
    wait_idle();
    check("R2 R4 count", n_log, 3);
    check("R2 order0", log_q[0], 2);
    check("R2 order1", log_q[1], 5);
    check("R2 order2", log_q[2], 9);

    // R2 sweep over pairs
    for (int b = 0; b < NB; b++) begin
      b2 = (b * 7 + 3) % NB;
      lo = (b < b2) ? b : b2;
      hi = (b < b2) ? b2 : b;
      n_log = 0;
      pick(b);
      pick(b2);
      wait_idle();
      check("R2 sweep count", n_log, (b == b2) ? 1 : 2);
      check("R2 sweep first", log_q[0], lo);
      if (b != b2) check("R2 sweep second", log_q[1], hi);
    end

    // R5 sweep: protected block skipped
    for (int b = 0; b < NB; b++) begin
      prot = NB'(1) << b;
      n_log = 0;
      pick(b);
      pick((b + 1) % NB);
      wait_idle();
      check("R5 only unprotected erased", n_log, 1);
      check("R5 erased block", log_q[0], (b + 1) % NB);
    end

    // R6: all protected
    prot = NB'(1) << 5;
    n_log = 0; saw = 0;
    pick(5);
    cnt = 1;
    while (busy && cnt < 100) begin
      if (req) saw = 1;
      @(negedge clk); cnt++;
    end
    check("R6 busy span", cnt - 1, WIN + DRN + 1);
    check("R6 no request", saw + n_log, 0);
    prot = '0;
    @(negedge clk);

    // R7 R8 R4 R9: suspend in window
    n_log = 0;
    pick(4);
    pulse_susp();
    check("R7 suspended immediately", int'(suspd), 1);
    check("R7 busy low", int'(busy), 0);
    pick(1);
    saw = 0;
    for (int i = 0; i < 20; i++) begin if (req) saw = 1; @(negedge clk); end
    check("R7 no request while suspended", saw, 0);
    rd_arr = 1'b0;
    pulse_resume();
    rd_arr = 1'b1;
    check("R9 resume outside array read ignored", int'(suspd), 1);
    abrt = 1'b1; @(negedge clk); abrt = 1'b0;
    check("R13 abort in suspend ignored", int'(suspd), 1);
    pulse_resume();
    check("R8 suspended cleared", int'(suspd), 0);
    check("R8 not yet requesting", int'(req), 0);
    @(negedge clk);
    check("R8 request after resume", int'(req), 1);
    pick(0);
    wait_idle();
    check("R4 R13 count after resume", n_log, 1);
    check("R8 erased block", log_q[0], 4);

    // R10 R11: suspend during erasing, repeated
    n_log = 0;
    pick(1); pick(2); pick(3);
    wait_req(k);
    pulse_susp();
    check("R10 not suspended mid-step", int'(suspd), 0);
    check("R10 request held", int'(req), 1);
    abrt = 1'b1; @(negedge clk); abrt = 1'b0;
    check("R13 abort while erasing ignored", int'(req), 1);
    wait_susp();
    check("R10 suspended after step", int'(suspd), 1);
    check("R10 next block shown", int'(cblk), 2);
    check("R10 first done", n_log, 1);
    saw = 0;
    for (int i = 0; i < 15; i++) begin if (req) saw = 1; @(negedge clk); end
    check("R10 quiet in suspend", saw, 0);
    pulse_resume();
    wait_req(k);
    pulse_susp();
    wait_susp();
    check("R11 second suspend", int'(suspd), 1);
    check("R11 next block", int'(cblk), 3);
    pulse_resume();
    wait_idle();
    check("R11 total erased", n_log, 3);
    check("R11 order1", log_q[1], 2);
    check("R11 order2", log_q[2], 3);

    // R12: abort during window
    n_log = 0; saw = 0;
    pick(6);
    abrt = 1'b1; @(negedge clk); abrt = 1'b0;
    cnt = 1;
    while (busy && cnt < 100) begin
      if (req) saw = 1;
      @(negedge clk); cnt++;
    end
    check("R12 abort busy span", cnt - 1, ABT);
    repeat (WIN + 4) begin if (req) saw = 1; @(negedge clk); end
    check("R12 no erasure", saw + n_log, 0);

    // R14: stable request across engine latency
    n_log = 0;
    pick(7);
    wait_req(k);
    saw = 0;
    for (int i = 0; i < LAT - 1; i++) begin
      if (!req || eblk != BW'(7)) saw = 1;
      @(negedge clk);
    end
    check("R14 request stable", saw, 0);
    @(negedge clk);
    check("R14 request released", int'(req), 0);
    wait_idle();
    check("R14 one erase", n_log, 1);

    summary();
  end
endmodule